// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit holds the 13-bit instruction address of a small 8-bit controller. It also holds a 5-bit page register that supplies the upper address bits for jumps. Each cycle the counter either steps to the next word or is redirected. A redirect comes from an interrupt, from an absolute jump or call built from an 11-bit opcode field, from a return, or from a computed jump. A computed jump is made by writing the counter's low byte.

The page register and the counter never update each other. A computed jump takes its top five bits from the page register. An absolute jump or call takes only page bits 4:3 for address bits 12:11. Plain stepping carries across 256-word boundaries without reading or changing the page register.

Return addresses are kept in an 8-entry circular hardware stack. A one-cycle `flush` output tells the fetch stage to discard the word it already fetched after any redirect.

Top module: `pc_page_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter goes to 0, the page register to 0, `flush` to 0 and the stack pointer to its first slot. This happens whatever else is asserted.
- R2: The page register stores bits 4:0 of `page_wr_data` on an edge where `page_wr_en` is high, and changes on no other event. `page_rd` bits 7:5 always read 0.
- R3: With `cf_op` = 0 (step) and no interrupt, the counter increments by one. The carry passes from bit 7 into bits 12:8, and 0x1FFF wraps to 0.
- R4: `irq_take` has priority over `cf_op`. It loads 4 into the counter and pushes the current counter value onto the stack.
- R5: With `cf_op` = 4 (computed jump), the counter becomes {page[4:0], `pcl_wr_data`}. The page value used is the one held before that edge.
- R6: With `cf_op` = 1 (goto), the counter becomes {page[4:3], `op_addr`[10:0]}.
- R7: With `cf_op` = 2 (call), the counter gets the same target as R6, and the current counter value plus one is pushed.
- R8: With `cf_op` = 3 (return), the most recently pushed address is popped into the counter.
- R9: The stack holds 8 entries and wraps with no flag. A ninth push overwrites the oldest entry. A pop past the last pushed entry reads the slot that wraps around.
- R10: `flush` is high for exactly the cycle after an edge that took an interrupt or a `cf_op` of 1 to 4, and low after a step.
- R11: `pcl_rd` always equals counter bits 7:0.
- R12: `cf_op` codes 5, 6 and 7 behave as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Take interrupt this cycle |
| cf_op | input | 3 | Control-flow code: 0 step, 1 goto, 2 call, 3 return, 4 computed jump |
| op_addr | input | 11 | Address field of the goto/call opcode |
| pcl_wr_data | input | 8 | Value written to the counter low byte |
| page_wr_en | input | 1 | Write strobe of the page register |
| page_wr_data | input | 8 | Data written to the page register |
| pc_out | output | 13 | Current instruction address |
| pcl_rd | output | 8 | Low-byte read value |
| page_rd | output | 8 | Page register read value |
| flush | output | 1 | Discard the prefetched instruction |

## Verification
The hardest conditions to reach are stack wrap-around and the same-edge case where the page register is written together with a computed jump. The wrap case needs nine nested calls before any return, and the bench issues them back to back, then nine returns in a row. The bench also pairs a page write with a computed jump in one cycle, and asserts an interrupt together with a goto and together with reset. The reference model predicts the counter, page register and flush every clock.

// File: rtl/pc_page_pkg.sv
package pc_page_pkg;
  localparam int PC_W      = 13;
  localparam int BYTE_W    = 8;
  localparam int OPF_W     = 11;
  localparam int STK_DEPTH = 8;
  localparam int IRQ_VEC   = 4;

  typedef enum logic [2:0] {
    CF_STEP = 3'd0,
    CF_GOTO = 3'd1,
    CF_CALL = 3'd2,
    CF_RET  = 3'd3,
    CF_PCLW = 3'd4
  } cf_op_e;
endpackage

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
  parameter int LW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [LW-1:0] q,
  output logic [DW-1:0] rd
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data[LW-1:0];
  end

  assign rd = {{(DW-LW){1'b0}}, q};
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp;
  logic [PW-1:0] sp_inc, sp_dec;

  assign sp_inc = (sp == LAST) ? '0 : sp + PW'(1);
  assign sp_dec = (sp == '0) ? LAST : sp - PW'(1);

  always_ff @(posedge clk) begin
    if (push && !rst) mem[sp] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp_inc;
    else if (pop)  sp <= sp_dec;
  end

  assign top = mem[sp_dec];
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_page_pkg::*;
#(
  parameter int AW  = 13,
  parameter int DW  = 8,
  parameter int OW  = 11,
  parameter int VEC = 4
) (
  input  logic [AW-1:0]    pc,
  input  logic             irq,
  input  logic [2:0]       op,
  input  logic [OW-1:0]    op_addr,
  input  logic [DW-1:0]    pcl_data,
  input  logic [AW-DW-1:0] page,
  input  logic [AW-1:0]    stk_top,
  output logic [AW-1:0]    nxt_pc,
  output logic             push,
  output logic             pop,
  output logic [AW-1:0]    push_val,
  output logic             redirect
);
  localparam int LW = AW - DW;
  localparam int HW = AW - OW;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] abs_tgt;

  assign seq_pc  = pc + AW'(1);
  assign abs_tgt = {page[LW-1 -: HW], op_addr};

  always_comb begin
    nxt_pc   = seq_pc;
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc;
    redirect = 1'b0;
    if (irq) begin
      nxt_pc   = AW'(VEC);
      push     = 1'b1;
      push_val = pc;
      redirect = 1'b1;
    end else begin
      case (op)
        CF_GOTO: begin
          nxt_pc   = abs_tgt;
          redirect = 1'b1;
        end
        CF_CALL: begin
          nxt_pc   = abs_tgt;
          push     = 1'b1;
          push_val = seq_pc;
          redirect = 1'b1;
        end
        CF_RET: begin
          nxt_pc   = stk_top;
          pop      = 1'b1;
          redirect = 1'b1;
        end
        CF_PCLW: begin
          nxt_pc   = {page, pcl_data};
          redirect = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pc_page_unit.sv
module pc_page_unit
  import pc_page_pkg::*;
#(
  parameter int AW    = PC_W,
  parameter int DW    = BYTE_W,
  parameter int OW    = OPF_W,
  parameter int DEPTH = STK_DEPTH,
  parameter int VEC   = IRQ_VEC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_take,
  input  logic [2:0]    cf_op,
  input  logic [OW-1:0] op_addr,
  input  logic [DW-1:0] pcl_wr_data,
  input  logic          page_wr_en,
  input  logic [DW-1:0] page_wr_data,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] pcl_rd,
  output logic [DW-1:0] page_rd,
  output logic          flush
);
  localparam int LW = AW - DW;

  logic [AW-1:0] pc_q;
  logic [LW-1:0] page_q;
  logic [AW-1:0] nxt_pc, push_val, stk_top;
  logic          push, pop, redirect;

  pc_page_latch #(.LW(LW), .DW(DW)) u_latch (
    .clk(clk), .rst(rst), .wr_en(page_wr_en), .wr_data(page_wr_data),
    .q(page_q), .rd(page_rd)
  );

  pc_next_sel #(.AW(AW), .DW(DW), .OW(OW), .VEC(VEC)) u_sel (
    .pc(pc_q), .irq(irq_take), .op(cf_op), .op_addr(op_addr),
    .pcl_data(pcl_wr_data), .page(page_q), .stk_top(stk_top),
    .nxt_pc(nxt_pc), .push(push), .pop(pop), .push_val(push_val),
    .redirect(redirect)
  );

  pc_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_val(push_val), .top(stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      flush <= 1'b0;
    end else begin
      pc_q  <= nxt_pc;
      flush <= redirect;
    end
  end

  assign pc_out = pc_q;
  assign pcl_rd = pc_q[DW-1:0];
endmodule

// File: rtl/pc_page_unit_chk.sv
module pc_page_unit_chk #(
  parameter int AW  = 13,
  parameter int DW  = 8,
  parameter int OW  = 11,
  parameter int VEC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_take,
  input logic [2:0]    cf_op,
  input logic [OW-1:0] op_addr,
  input logic [DW-1:0] pcl_wr_data,
  input logic          page_wr_en,
  input logic [AW-1:0] pc_out,
  input logic [DW-1:0] page_rd,
  input logic          flush
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  logic is_step;
  assign is_step = !irq_take && (cf_op == 3'd0 || cf_op > 3'd4);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    seen && $past(rst) |-> pc_out == '0 && page_rd == '0 && !flush);

  p_page_hold_r2: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && !$past(page_wr_en) |-> $stable(page_rd));

  p_page_upper_r2: assert property (@(posedge clk) disable iff (rst)
    seen |-> page_rd[DW-1:AW-DW] == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(is_step) |-> pc_out == $past(pc_out) + AW'(1));

  p_irq_vec_r4: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(irq_take) |-> pc_out == AW'(VEC));

  p_pcl_jump_r5: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && !$past(irq_take) && $past(cf_op) == 3'd4
    |-> pc_out == {$past(page_rd[AW-DW-1:0]), $past(pcl_wr_data)});

  p_goto_r6: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && !$past(irq_take) && $past(cf_op) == 3'd1
    |-> pc_out == {$past(page_rd[AW-DW-1:AW-DW-(AW-OW)]), $past(op_addr)});

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) |-> flush == !$past(is_step));
endmodule

bind pc_page_unit pc_page_unit_chk #(.AW(AW), .DW(DW), .OW(OW), .VEC(VEC)) chk_i (
  .clk(clk), .rst(rst), .irq_take(irq_take), .cf_op(cf_op), .op_addr(op_addr),
  .pcl_wr_data(pcl_wr_data), .page_wr_en(page_wr_en), .pc_out(pc_out),
  .page_rd(page_rd), .flush(flush)
);

// File: tb/pc_page_unit_tb.sv
module pc_page_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_take = 1'b0;
  logic [2:0]  cf_op = 3'd0;
  logic [10:0] op_addr = '0;
  logic [7:0]  pcl_wr_data = '0;
  logic        page_wr_en = 1'b0;
  logic [7:0]  page_wr_data = '0;
  logic [12:0] pc_out;
  logic [7:0]  pcl_rd, page_rd;
  logic        flush;

  int checks = 0;
  int failures = 0;

  int m_pc = 0, m_page = 0, m_sp = 0, m_flush = 0;
  int m_stk [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_page_unit dut_i (
    .clk(clk), .rst(rst), .irq_take(irq_take), .cf_op(cf_op), .op_addr(op_addr),
    .pcl_wr_data(pcl_wr_data), .page_wr_en(page_wr_en), .page_wr_data(page_wr_data),
    .pc_out(pc_out), .pcl_rd(pcl_rd), .page_rd(page_rd), .flush(flush)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit irq, input int op, input int adr,
                      input int pd, input bit lwe, input int ld);
    int old_page;
    string tag;
    rst = r; irq_take = irq; cf_op = 3'(op); op_addr = 11'(adr);
    pcl_wr_data = 8'(pd); page_wr_en = lwe; page_wr_data = 8'(ld);
    old_page = m_page;
    if (r) begin
      m_pc = 0; m_page = 0; m_sp = 0; m_flush = 0; tag = "R1";
    end else begin
      if (lwe) m_page = ld & 'h1F;
      m_flush = 1;
      if (irq) begin
        m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 4; tag = "R4";
      end else if (op == 1) begin
        m_pc = ((old_page >> 3) & 3) * 2048 + (adr & 'h7FF); tag = "R6";
      end else if (op == 2) begin
        m_stk[m_sp] = (m_pc + 1) % 8192; m_sp = (m_sp + 1) % 8;
        m_pc = ((old_page >> 3) & 3) * 2048 + (adr & 'h7FF); tag = "R7";
      end else if (op == 3) begin
        m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; tag = "R8_R9";
      end else if (op == 4) begin
        m_pc = old_page * 256 + (pd & 'hFF); tag = "R5";
      end else begin
        m_pc = (m_pc + 1) % 8192; m_flush = 0;
        tag = (op == 0) ? "R3" : "R12";
      end
    end
    @(posedge clk);
    #1;
    check(tag, "pc_out", int'(pc_out), m_pc);
    check(r ? "R1" : "R10", "flush", int'(flush), m_flush);
    check(r ? "R1" : "R2", "page_rd", int'(page_rd), m_page);
    check("R11", "pcl_rd", int'(pcl_rd), m_pc % 256);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_stk[k] = 0;
    // R1: reset dominates interrupt, page write and goto
    step(1, 1, 1, 'h123, 0, 1, 'hFF);
    step(1, 0, 0, 0, 0, 0, 0);
    idle(3);                                   // R3 plain stepping
    step(0, 0, 0, 0, 0, 1, 'hFF);              // R2 upper bits read zero
    idle(2);                                   // R2 page holds
    step(0, 0, 1, 'h7FE, 0, 0, 0);             // R6 goto -> 0x1FFE
    idle(3);                                   // R3 wrap 0x1FFF -> 0
    step(0, 0, 0, 0, 0, 1, 'h00);
    step(0, 0, 1, 'h0FE, 0, 0, 0);             // R6 goto 0x0FE
    idle(3);                                   // R3 carry into bit 8
    step(0, 0, 0, 0, 0, 1, 'h15);
    step(0, 0, 4, 0, 'h34, 1, 'h02);           // R5 uses old page 0x15
    idle(1);
    step(0, 0, 2, 'h123, 0, 0, 0);             // R7 call, page bits 4:3 = 0
    idle(2);
    step(0, 0, 3, 0, 0, 0, 0);                 // R8 return
    step(0, 0, 0, 0, 0, 1, 'h18);
    step(0, 0, 2, 'h456, 0, 0, 0);             // R7 call with page bits 4:3 = 3
    step(0, 1, 1, 'h7FF, 0, 0, 0);             // R4 interrupt beats goto
    idle(1);
    step(0, 0, 3, 0, 0, 0, 0);                 // R8 back to interrupted address
    step(0, 0, 3, 0, 0, 0, 0);                 // R8 back after call
    step(0, 0, 5, 0, 0, 0, 0);                 // R12
    step(0, 0, 6, 0, 0, 0, 0);                 // R12
    step(0, 0, 7, 0, 0, 0, 0);                 // R12
    for (int k = 0; k < 9; k++) step(0, 0, 2, 'h100 + k * 8, 0, 0, 0);   // R9 overflow
    for (int k = 0; k < 9; k++) step(0, 0, 3, 0, 0, 0, 0);               // R9 underflow
    step(0, 0, 4, 0, 'hFF, 0, 0);              // R5
    step(1, 1, 3, 0, 0, 0, 0);                 // R1 mid-run reset
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule